// File: doc/BRIEF.md
# Debounced Input Change-of-State Detector

This block watches a group of general-purpose input pins and reports when any of them settles at a new level. Each pin first passes through a two-flop synchronizer. A divider turns the system clock into a slow sampling tick, with a nominal rate of 38.4 kHz. A new level is accepted only when two successive tick samples both disagree with the level accepted before. A pin therefore has to hold its new level for one to two tick periods before the change counts. Because the tick comes from dividing the clock, this window scales with the clock frequency.

Each accepted change sets a sticky per-pin change flag. An interrupt request is raised while any flagged pin is also enabled. Software reads the debounced pin levels and the change flags together. The read strobe clears every flag and discards any half-confirmed sample. A change confirmed in the same cycle as a clearing read is kept, so that no event is lost.

Top module: `pin_cos_detect`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `level_o`, `delta_o` and `irq_o` are all zero.
- R2: The sampling tick fires once every `TICK_DIV` clock cycles. A pin level driven before a clock edge takes between `TICK_DIV+3` and `2*TICK_DIV+2` clock edges to appear on `level_o`.
- R3: A pin's accepted level flips only when two successive tick samples of the synchronized pin both differ from the accepted level. On that edge, `level_o[i]` takes the new value and `delta_o[i]` is set.
- R4: A pin that returns to its accepted level before a second disagreeing tick sample leaves `level_o` and `delta_o` unchanged.
- R5: A set `delta_o[i]` stays set until a cycle with `rd_clr_i` high. That clearing read zeroes every delta bit at the next edge.
- R6: A cycle with `rd_clr_i` high discards any pending first sample. While `rd_clr_i` is held high, no new level is accepted.
- R7: If a change is confirmed on the same edge as a clearing read, that pin's delta bit is set after the edge.
- R8: `irq_o` is high exactly when some bit of `delta_o & irq_en_i` is high. `irq_en_i` acts without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | PINS | Raw asynchronous input pins |
| irq_en_i | input | PINS | Per-pin interrupt enable |
| rd_clr_i | input | 1 | One-cycle read strobe; clears delta flags and pending samples |
| level_o | output | PINS | Debounced accepted pin levels |
| delta_o | output | PINS | Sticky per-pin change flags |
| irq_o | output | 1 | Interrupt request |

## Verification
Outputs are due at these points:
- A confirmed change shows on `level_o` and `delta_o` one edge after the confirming tick cycle. Counted from the pin edge, that is two synchronizer edges plus one to two tick periods.
- A clearing read takes effect one edge after its strobe.
- `irq_o` follows `irq_en_i` within the same cycle.

The bench drives all inputs on falling edges. It carries a cycle-level model of the tick phase, synchronizer and confirmation rule, derived from the requirements. It compares every output at each falling edge, so each check lands after the edge that should have produced the result.

The directed cases cover:
- the latency window, measured as an edge count;
- a one-cycle glitch;
- a held read strobe;
- a read placed on the confirming tick cycle, located from the modelled tick phase.

// File: rtl/cos_pkg.sv
package cos_pkg;
    // Per-pin detector state: synchronizer pair, accepted level, pending first sample
    typedef struct packed {
        logic s1;
        logic s2;
        logic acc;
        logic pend;
    } det_state_t;
endpackage

// File: rtl/cos_tick_gen.sv
module cos_tick_gen #(
    parameter int TICK_DIV = 3255
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } tick_state_t;

    tick_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/cos_pin_detector.sv
module cos_pin_detector
    import cos_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic tick_i,
    input  logic clr_i,
    output logic level_o,
    output logic change_o
);
    det_state_t st_d, st_q;
    logic       chg;

    always_comb begin
        st_d    = st_q;
        chg     = 1'b0;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
        if (tick_i) begin
            if (st_q.s2 != st_q.acc) begin
                if (st_q.pend) begin
                    st_d.acc  = st_q.s2;
                    st_d.pend = 1'b0;
                    chg       = 1'b1;
                end else begin
                    st_d.pend = 1'b1;
                end
            end else begin
                st_d.pend = 1'b0;
            end
        end
        if (clr_i) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o  = st_q.acc;
    assign change_o = chg;

    // R3
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q.acc));
    // R3
    confirm_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.acc) |-> $past(st_q.pend));
    // R6
    clear_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !st_q.pend);
endmodule

// File: rtl/pin_cos_detect.sv
module pin_cos_detect #(
    parameter int PINS     = 4,
    parameter int TICK_DIV = 3255
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_i,
    input  logic [PINS-1:0] irq_en_i,
    input  logic            rd_clr_i,
    output logic [PINS-1:0] level_o,
    output logic [PINS-1:0] delta_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [PINS-1:0] delta;
    } top_state_t;

    top_state_t      st_d, st_q;
    logic            tick;
    logic [PINS-1:0] change;

    cos_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        cos_pin_detector i_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_i    (pin_i[g]),
            .tick_i   (tick),
            .clr_i    (rd_clr_i),
            .level_o  (level_o[g]),
            .change_o (change[g])
        );

        // R3
        delta_with_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.delta[g]) |-> !$stable(level_o[g]));
        // R5
        delta_falls_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(st_q.delta[g]) |-> $past(rd_clr_i));
        // R5
        read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr_i && !change[g]) |=> !st_q.delta[g]);
        // R7
        change_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
            change[g] |=> st_q.delta[g]);
    end

    always_comb begin
        st_d       = st_q;
        st_d.delta = (st_q.delta & ~{PINS{rd_clr_i}}) | change;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign delta_o = st_q.delta;
    assign irq_o   = |(st_q.delta & irq_en_i);

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (delta_o != '0));
endmodule

// File: tb/test_pin_cos_detect.sv
module test_pin_cos_detect;
    localparam int PINS = 4;
    localparam int DIV  = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PINS-1:0] pin = '0;
    logic [PINS-1:0] en = '0;
    logic            rd = 1'b0;
    logic [PINS-1:0] level_o, delta_o;
    logic            irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pin_cos_detect #(.PINS(PINS), .TICK_DIV(DIV)) i_pin_cos_detect (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .irq_en_i(en), .rd_clr_i(rd),
        .level_o(level_o), .delta_o(delta_o), .irq_o(irq_o)
    );

    // Reference model built from R2, R3, R4, R5, R6, R7
    int              m_cnt;
    logic            m_tick;
    logic [PINS-1:0] m_s1, m_s2, m_acc, m_pend, m_delta;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 0; m_tick <= 1'b0; m_s1 <= '0; m_s2 <= '0;
            m_acc <= '0; m_pend <= '0; m_delta <= '0;
        end else begin
            logic [PINS-1:0] acc_n, pend_n, chg;
            acc_n = m_acc; pend_n = m_pend; chg = '0;
            for (int i = 0; i < PINS; i++) begin
                if (m_tick) begin
                    if (m_s2[i] != m_acc[i]) begin
                        if (m_pend[i]) begin
                            acc_n[i] = m_s2[i]; pend_n[i] = 1'b0; chg[i] = 1'b1;
                        end else pend_n[i] = 1'b1;
                    end else pend_n[i] = 1'b0;
                end
                if (rd) pend_n[i] = 1'b0;
            end
            m_tick  <= (m_cnt == DIV - 1);
            m_cnt   <= (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
            m_s1    <= pin;
            m_s2    <= m_s1;
            m_acc   <= acc_n;
            m_pend  <= pend_n;
            m_delta <= (m_delta & ~{PINS{rd}}) | chg;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        chk(level_o == m_acc, "R3 level", 32'(level_o), 32'(m_acc));
        chk(delta_o == m_delta, "R5 delta", 32'(delta_o), 32'(m_delta));
        chk(irq_o == |(m_delta & en), "R8 irq", 32'(irq_o), 32'(|(m_delta & en)));
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        int hold [PINS];
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(level_o == '0 && delta_o == '0 && irq_o == 1'b0, "R1 in reset", 32'({level_o, delta_o, irq_o}), 0);
        rst_n = 1'b1;
        step();
        chk(level_o == '0 && delta_o == '0 && irq_o == 1'b0, "R1 after release", 32'({level_o, delta_o, irq_o}), 0);

        // R2 latency window, R3 flag, R8 irq
        en = '1;
        pin[0] = 1'b1;
        n = 0;
        while (level_o[0] != 1'b1 && n < 40) begin step(); n++; end
        chk(n >= DIV + 3 && n <= 2 * DIV + 2, "R2 latency", 32'(n), 32'(DIV + 3));
        chk(delta_o[0] == 1'b1, "R3 delta set", 32'(delta_o[0]), 1);
        chk(irq_o == 1'b1, "R8 irq enabled", 32'(irq_o), 1);

        // R5 sticky then cleared
        repeat (5) step();
        chk(delta_o[0] == 1'b1, "R5 sticky", 32'(delta_o[0]), 1);
        rd = 1'b1; step(); rd = 1'b0;
        chk(delta_o == '0, "R5 cleared", 32'(delta_o), 0);
        chk(irq_o == 1'b0, "R8 irq low after clear", 32'(irq_o), 0);

        // R4 glitch rejected
        pin[1] = 1'b1; step(); pin[1] = 1'b0;
        repeat (3 * DIV + 4) step();
        chk(level_o[1] == 1'b0 && delta_o[1] == 1'b0, "R4 glitch", 32'({level_o[1], delta_o[1]}), 0);

        // R8 mask
        en = '0; pin[2] = 1'b1;
        repeat (3 * DIV) step();
        chk(delta_o[2] == 1'b1 && irq_o == 1'b0, "R8 masked", 32'({delta_o[2], irq_o}), 32'b10);
        en[2] = 1'b1; step();
        chk(irq_o == 1'b1, "R8 unmasked", 32'(irq_o), 1);
        rd = 1'b1; step(); rd = 1'b0;

        // R6 held read blocks acceptance
        pin[3] = 1'b1; rd = 1'b1;
        repeat (4 * DIV) step();
        chk(level_o[3] == 1'b0, "R6 held read", 32'(level_o[3]), 0);
        rd = 1'b0;
        repeat (3 * DIV) step();
        chk(level_o[3] == 1'b1 && delta_o[3] == 1'b1, "R6 accepted after", 32'({level_o[3], delta_o[3]}), 32'b11);
        rd = 1'b1; step(); rd = 1'b0;

        // R7 read on the confirming cycle
        pin[0] = 1'b0;
        n = 0;
        while (!(m_pend[0] && m_tick) && n < 40) begin step(); n++; end
        rd = 1'b1; step(); rd = 1'b0;
        chk(delta_o[0] == 1'b1 && level_o[0] == 1'b0, "R7 kept", 32'({delta_o[0], level_o[0]}), 32'b10);

        // Random phase: R3 R4 R5 R6 R7 R8 against the model
        for (int i = 0; i < PINS; i++) hold[i] = 0;
        for (int k = 0; k < 3000; k++) begin
            step();
            for (int i = 0; i < PINS; i++) begin
                if (hold[i] == 0) begin
                    pin[i] = ~pin[i];
                    case ($urandom % 4)
                        0: hold[i] = 1;
                        1: hold[i] = DIV - 1;
                        2: hold[i] = 2 * DIV + 3;
                        default: hold[i] = 5 * DIV;
                    endcase
                end else hold[i]--;
            end
            rd = ($urandom % 16) == 0;
            if (($urandom % 64) == 0) en = PINS'($urandom);
        end
        rd = 1'b0;
        step();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule